// File: doc/BRIEF.md
# Descriptor-Chained DMA Engine

This block is a single-channel DMA engine. It walks a linked list of descriptors held in memory and moves each described buffer between memory and a byte-wide device stream. Every descriptor is three consecutive 32-bit words: the buffer byte address, a count/flags word, and the byte address of the next descriptor. Software writes the address of the first descriptor into the next-descriptor register. It then starts the channel through the control register. From that point the engine fetches, transfers and chains on its own until it reaches a descriptor marked as the end of the chain.

In transmit direction the engine reads the buffer bytes in ascending address order and presents them on a valid/ready output stream. It can mark the final byte as the end of a packet. When a buffer has been sent, it records completion in the descriptor. In receive direction it accepts bytes from a valid/ready input stream and stores them one byte at a time. If the packet ends before the buffer is full, it writes the received length back into the descriptor. A per-descriptor flag raises an interrupt flag. Software reads that flag through the control register, and the read clears it.

The memory side is a word-wide port with a request/grant handshake. Read data is valid in the cycle of the grant. Writes carry a byte-lane enable.

Top module: `dchain_dma`

## Requirements
- R1: A control write (select 1) starts the channel only when bit 4 and bit 5 are both set in the same write. Bit 2 of that write selects receive (1) or transmit (0). A write with bit 4 alone leaves the channel idle.
- R2: For each descriptor at address D, the engine reads the words at D, D+4 and D+8 before it moves any buffer data. The memory request, address and write flag stay stable while the grant is low.
- R3: After fetching a descriptor, the engine copies that descriptor's next-pointer word into the next-descriptor register. Software reads this register at select 0.
- R4: In transmit, byte i of a buffer at address A comes from the memory word at (A+i) with the low two bits cleared, in lane (A+i)[1:0]. Lane k occupies bits 8k+7:8k. Bytes leave in ascending i, and data stays stable while ready is low.
- R5: In transmit, the last-byte marker is high on the final byte of a buffer exactly when count/flags bit 30 is set, and it is low on all other bytes.
- R6: In transmit, after a buffer with a non-zero count has been sent, the descriptor's count/flags word is rewritten with bit 15 set and every other bit unchanged.
- R7: In receive, each byte is written to the word at (A+i) with the low two bits cleared, with a single byte enable for lane (A+i)[1:0]. Neighbouring bytes are left untouched.
- R8: In receive, if the input last marker arrives before the count (bits 13:0) is reached, the engine replaces bits 13:0 with the number of bytes received, keeps bits 31:14, and moves on. If the buffer fills, the word is not rewritten.
- R9: A descriptor with a zero count moves no data and is not written back. Its bit 29 and bit 31 are still acted upon.
- R10: After the buffer of a descriptor with bit 31 set, the engine stops and control read bit 1 (active) drops to 0. Otherwise it fetches the descriptor at the next pointer.
- R11: Finishing a descriptor with bit 29 set raises the pending-interrupt flag. The flag drives the irq output and reads as control bit 0. A control read clears it.
- R12: If the engine raises a new interrupt in the same cycle as a clearing control read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a control read clears the interrupt flag) |
| reg_sel | input | 1 | Register select: 0 next-descriptor pointer, 1 control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| irq | output | 1 | Pending-interrupt flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned for data) |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant; the access completes in this cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Device accepts transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit end-of-packet marker |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts receive byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive end-of-packet marker |

## Verification
The two functions that can land on the same clock edge are the engine raising the interrupt flag and software clearing it with a control read. The bench builds a chain of two zero-count descriptors, both requesting an interrupt, and turns memory stalls off so that the second interrupt arrives exactly eight edges after the start write. It times a control read to that edge, while the first interrupt is still pending. It then expects the next read to show the flag still set and the read after it to show the flag cleared. Losing either interrupt counts as a failure.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 14;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int W_BYTES = WORD_W / BYTE_W;

    // count/flags word bit positions
    localparam int F_CHAIN_END = 31;
    localparam int F_PKT_END   = 30;
    localparam int F_IRQ_REQ   = 29;
    localparam int F_DONE      = 15;

    // control write / read bit positions
    localparam int C_RX     = 2;
    localparam int C_GO     = 4;
    localparam int C_ARM    = 5;
    localparam int R_PEND   = 0;
    localparam int R_ACTIVE = 1;

    localparam logic SEL_PTR  = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    typedef enum logic [3:0] {
        S_IDLE, S_F0, S_F1, S_F2, S_RD, S_TX, S_RXW, S_WR, S_WB, S_FIN
    } wstate_t;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic [WORD_W-1:0] ctl;
        logic [ADDR_W-1:0] nxt;
    } desc_t;

    function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    endfunction

    function automatic logic [CNT_W-1:0] count_of(input logic [WORD_W-1:0] ctl);
        return ctl[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/dchain_lane.sv
module dchain_lane
    import dchain_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANE_W-1:0] sel_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] wdata_o
);
    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g]                      = word_i[g*BYTE_W +: BYTE_W];
        assign be_o[g]                       = (sel_i == LANE_W'(g));
        assign wdata_o[g*BYTE_W +: BYTE_W]   = byte_i;
    end

    assign byte_o = lanes[sel_i];
endmodule

// File: rtl/dchain_regs.sv
module dchain_regs
    import dchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              eng_ptr_we,
    input  logic [ADDR_W-1:0] eng_ptr_val,
    input  logic              eng_irq_set,
    input  logic              eng_active,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              start_o,
    output logic              start_rx_o,
    output logic              irq_o
);
    logic [ADDR_W-1:0] ptr_q;
    logic              pend_q;
    logic              ctrl_rd;

    assign ctrl_rd    = reg_rd && (reg_sel == SEL_CTRL);
    assign start_o    = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[C_GO]
                        && reg_wdata[C_ARM] && !eng_active;
    assign start_rx_o = reg_wdata[C_RX];
    assign ptr_o      = ptr_q;
    assign irq_o      = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (eng_ptr_we)
                ptr_q <= eng_ptr_val;
            else if (reg_wr && reg_sel == SEL_PTR)
                ptr_q <= reg_wdata;
            // a new interrupt outranks a clearing read on the same edge
            if (eng_irq_set)
                pend_q <= 1'b1;
            else if (ctrl_rd)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_PTR) begin
            reg_rdata = ptr_q;
        end else begin
            reg_rdata[R_PEND]   = pend_q;
            reg_rdata[R_ACTIVE] = eng_active;
        end
    end

    // R12: an interrupt raised by the engine is never lost
    p_irq_keep_r12: assert property (@(posedge clk) disable iff (rst)
        eng_irq_set |=> pend_q);

    // R11: a control read with no new interrupt clears the flag
    p_rdclr_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_rd && !eng_irq_set) |=> !pend_q);
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
    import dchain_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              start_rx_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              ptr_we_o,
    output logic [ADDR_W-1:0] ptr_val_o,
    output logic              irq_set_o,
    output logic              active_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_last,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_last
);
    wstate_t           st_q;
    desc_t             desc_q;
    logic [ADDR_W-1:0] cur_q;
    logic [CNT_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] rxb_q;
    logic              rxl_q;
    logic              rx_q;

    logic [ADDR_W-1:0] byte_addr;
    logic              last_byte;
    logic [BYTE_W-1:0] lane_byte;
    logic [LANES-1:0]  lane_be;
    logic [WORD_W-1:0] lane_word;
    logic [WORD_W-1:0] wb_word;

    assign byte_addr = desc_q.buf_addr + ADDR_W'(idx_q);
    assign last_byte = (idx_q + CNT_W'(1)) == count_of(desc_q.ctl);

    dchain_lane u_lane (
        .word_i  (word_q),
        .sel_i   (byte_addr[LANE_W-1:0]),
        .byte_i  (rxb_q),
        .byte_o  (lane_byte),
        .be_o    (lane_be),
        .wdata_o (lane_word)
    );

    always_comb begin
        wb_word = desc_q.ctl;
        if (rx_q)
            wb_word[CNT_W-1:0] = idx_q;
        else
            wb_word[F_DONE] = 1'b1;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_be    = '1;
        mem_wdata = wb_word;
        unique case (st_q)
            S_F0: mem_req = 1'b1;
            S_F1: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + ADDR_W'(W_BYTES);
            end
            S_F2: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + ADDR_W'(2 * W_BYTES);
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = align_word(byte_addr);
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = align_word(byte_addr);
                mem_be    = lane_be;
                mem_wdata = lane_word;
            end
            S_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cur_q + ADDR_W'(W_BYTES);
            end
            default: ;
        endcase
    end

    assign ptr_we_o  = (st_q == S_F2) && mem_gnt;
    assign ptr_val_o = mem_rdata;
    assign irq_set_o = (st_q == S_FIN) && desc_q.ctl[F_IRQ_REQ];
    assign active_o  = (st_q != S_IDLE);
    assign tx_valid  = (st_q == S_TX);
    assign tx_data   = lane_byte;
    assign tx_last   = tx_valid && last_byte && desc_q.ctl[F_PKT_END];
    assign rx_ready  = (st_q == S_RXW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            desc_q <= '0;
            cur_q  <= '0;
            idx_q  <= '0;
            word_q <= '0;
            rxb_q  <= '0;
            rxl_q  <= 1'b0;
            rx_q   <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start_i) begin
                    rx_q  <= start_rx_i;
                    cur_q <= ptr_i;
                    st_q  <= S_F0;
                end
                S_F0: if (mem_gnt) begin
                    desc_q.buf_addr <= mem_rdata;
                    st_q            <= S_F1;
                end
                S_F1: if (mem_gnt) begin
                    desc_q.ctl <= mem_rdata;
                    st_q       <= S_F2;
                end
                S_F2: if (mem_gnt) begin
                    desc_q.nxt <= mem_rdata;
                    idx_q      <= '0;
                    if (count_of(desc_q.ctl) == '0) st_q <= S_FIN;
                    else if (rx_q)                  st_q <= S_RXW;
                    else                            st_q <= S_RD;
                end
                S_RD: if (mem_gnt) begin
                    word_q <= mem_rdata;
                    st_q   <= S_TX;
                end
                S_TX: if (tx_ready) begin
                    idx_q <= idx_q + CNT_W'(1);
                    st_q  <= last_byte ? S_WB : S_RD;
                end
                S_RXW: if (rx_valid) begin
                    rxb_q <= rx_data;
                    rxl_q <= rx_last;
                    st_q  <= S_WR;
                end
                S_WR: if (mem_gnt) begin
                    idx_q <= idx_q + CNT_W'(1);
                    if (last_byte)  st_q <= S_FIN;
                    else if (rxl_q) st_q <= S_WB;
                    else            st_q <= S_RXW;
                end
                S_WB: if (mem_gnt) st_q <= S_FIN;
                S_FIN: begin
                    if (desc_q.ctl[F_CHAIN_END]) begin
                        st_q <= S_IDLE;
                    end else begin
                        cur_q <= desc_q.nxt;
                        st_q  <= S_F0;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R2: a pending memory access holds still until granted
    p_mem_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: transmit byte and marker hold while the device stalls
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R7: a data write touches one lane, a write-back touches the whole word
    p_be_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 || mem_be == '1));

    // R10: an idle engine issues no traffic on any side
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> (!mem_req && !tx_valid && !rx_ready));
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dchain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_gnt,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    logic [ADDR_W-1:0] ptr;
    logic              start;
    logic              start_rx;
    logic              ptr_we;
    logic [ADDR_W-1:0] ptr_val;
    logic              irq_set;
    logic              active;

    dchain_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .eng_ptr_we  (ptr_we),
        .eng_ptr_val (ptr_val),
        .eng_irq_set (irq_set),
        .eng_active  (active),
        .ptr_o       (ptr),
        .start_o     (start),
        .start_rx_o  (start_rx),
        .irq_o       (irq)
    );

    dchain_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .start_rx_i (start_rx),
        .ptr_i      (ptr),
        .ptr_we_o   (ptr_we),
        .ptr_val_o  (ptr_val),
        .irq_set_o  (irq_set),
        .active_o   (active),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_gnt    (mem_gnt),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_data    (rx_data),
        .rx_last    (rx_last)
    );

    // R1: the channel becomes active only after an armed start write
    p_start_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ($past(reg_wr) && $past(reg_sel) &&
                           $past(reg_wdata[C_GO]) && $past(reg_wdata[C_ARM])));
endmodule

// File: tb/dchain_dma_tb_top.sv
module dchain_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        tx_valid, tx_ready, tx_last;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tx_seen = 0;
    logic stall_en = 1'b0;
    logic [3:0] pat = '0;
    logic [31:0] mem [256];
    logic [8:0] exp_q [$];

    always #2 clk = ~clk;   // 250 MHz

    dchain_dma dut_i (.*);

    // memory model: grant with optional stalls, read data valid with grant
    always @(posedge clk) pat <= pat + 4'd1;
    assign mem_gnt   = mem_req && (stall_en ? (pat[0] ^ pat[2]) : 1'b1);
    assign mem_rdata = mem[mem_addr[9:2]];
    assign tx_ready  = (pat[1:0] != 2'b10);

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we)
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] = mem_wdata[8*k +: 8];
    end

    function automatic logic [7:0] byte_at(input int a);
        return mem[(a >> 2) & 255][8*(a & 3) +: 8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor for the transmit stream
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            tx_seen++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected tx byte actual=%h expected=none", tx_data);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R4 R5 tx byte/last", {23'd0, tx_last, tx_data}, {23'd0, e});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic reg_write(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] d);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk); d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(output int irqs);
        logic [31:0] d;
        irqs = 0;
        do begin
            reg_read(1'b1, d);
            if (d[0]) irqs++;
        end while (d[1]);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic l);
        rx_valid = 1'b1; rx_data = b; rx_last = l;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        int irqs;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 64; i < 160; i++) mem[i] = (i * 32'h01030507) ^ 32'h5A3C_96E1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // reset state
        check("R11 irq after reset", {31'd0, irq}, 32'd0);
        reg_read(1'b1, d);
        check("R10 ctrl after reset", d, 32'd0);
        reg_read(1'b0, d);
        check("R3 pointer after reset", d, 32'd0);

        // R1: start bit without the arm bit does nothing
        reg_write(1'b1, 32'h0000_0010);
        repeat (3) @(posedge clk); #1;
        reg_read(1'b1, d);
        check("R1 unarmed start stays idle", {31'd0, d[1]}, 32'd0);

        // transmit chain: A (5 bytes, unaligned, packet end), B (zero count, irq), C (3 bytes, irq, end)
        mem[0] = 32'h0000_0101; mem[1] = 32'h4000_0005; mem[2] = 32'h0000_0010;
        mem[4] = 32'h0000_0200; mem[5] = 32'h2000_0000; mem[6] = 32'h0000_0020;
        mem[8] = 32'h0000_020E; mem[9] = 32'hA000_0003; mem[10] = 32'h0000_1230;
        for (int i = 0; i < 5; i++) exp_q.push_back({(i == 4), byte_at(32'h101 + i)});
        for (int i = 0; i < 3; i++) exp_q.push_back({1'b0, byte_at(32'h20E + i)});
        stall_en = 1'b1;
        reg_write(1'b0, 32'h0);
        reg_write(1'b1, 32'h0000_0030);
        wait_idle(irqs);
        check("R11 tx irq count", irqs, 32'd2);
        check("R2 R4 all tx bytes delivered", exp_q.size(), 32'd0);
        check("R9 no bytes for zero count", tx_seen, 32'd8);
        check("R6 done bit desc A", mem[1], 32'h4000_8005);
        check("R6 done bit desc C", mem[9], 32'hA000_8003);
        check("R9 zero count not written", mem[5], 32'h2000_0000);
        reg_read(1'b0, d);
        check("R3 pointer follows chain", d, 32'h0000_1230);
        reg_read(1'b1, d);
        check("R10 idle after chain end", {31'd0, d[1]}, 32'd0);

        // R12: second interrupt lands on the same edge as a clearing read
        stall_en = 1'b0;
        mem[24] = 32'h0; mem[25] = 32'h2000_0000; mem[26] = 32'h0000_0070;
        mem[28] = 32'h0; mem[29] = 32'hA000_0000; mem[30] = 32'h0;
        reg_write(1'b0, 32'h0000_0060);
        reg_write(1'b1, 32'h0000_0030);
        repeat (7) @(posedge clk); #1;
        reg_read(1'b1, d);
        check("R11 first irq pending", d, 32'h0000_0003);
        reg_read(1'b1, d);
        check("R12 irq kept on coincident clear", d, 32'h0000_0001);
        reg_read(1'b1, d);
        check("R11 irq cleared by read", d, 32'h0000_0000);

        // receive chain: early end in first buffer, exact fill in second
        stall_en = 1'b1;
        mem[32] = 32'h0000_0300; mem[33] = 32'h2000_0006; mem[34] = 32'h0000_0090;
        mem[36] = 32'h0000_0305; mem[37] = 32'h8000_0002; mem[38] = 32'h0000_0777;
        mem[192] = 32'hEEEE_EEEE; mem[193] = 32'hEEEE_EEEE;
        reg_write(1'b0, 32'h0000_0080);
        reg_write(1'b1, 32'h0000_0034);
        fork
            begin
                rx_send(8'h11, 1'b0);
                rx_send(8'h22, 1'b0);
                rx_send(8'h33, 1'b1);
                rx_send(8'h44, 1'b0);
                rx_send(8'h55, 1'b1);
            end
            wait_idle(irqs);
        join
        check("R7 rx bytes first word", mem[192], 32'hEE33_2211);
        check("R7 rx bytes second word", mem[193], 32'hEE55_44EE);
        check("R8 early end length", mem[33], 32'h2000_0003);
        check("R8 full buffer unchanged", mem[37], 32'h8000_0002);
        check("R11 rx irq count", irqs, 32'd1);
        reg_read(1'b0, d);
        check("R3 pointer after rx chain", d, 32'h0000_0777);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule